// File: doc/BRIEF.md
# Fractional-Rate PWM Generator with Deferred Settings Update

This block drives one PWM output pin. Its frequency comes from a 16-bit phase accumulator that adds a programmable step on every clock and wraps modulo 65536. The output period is therefore 65536 / step input clocks, and the step does not have to divide 65536 evenly. The output is high while the accumulator's upper byte is strictly greater than an 8-bit duty divisor. The duty is therefore stored inverted: a smaller divisor gives a longer high time.

Software reaches the block through one 32-bit register with byte-lane strobes.

- Bit 31 enables the output.
- Bit 30 requests an update.
- Bits 23:8 hold the step.
- Bits 7:0 hold the divisor.

New step and divisor values go into shadow storage. They reach the active settings only when the update request is set, and then only at the next period boundary. A period boundary is an accumulator wrap, or any clock while the block is disabled. The hardware clears the request when it applies the new values, so software can poll the request bit to see that the update has completed.

Top module: `frac_pwm`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0 and the output is low.
- R2: While the enable bit (bit 31) is 0, the output is low and the accumulator is held at zero.
- R3: While enabled, the accumulator adds the active step on every clock, modulo 65536. After the n-th enabled clock edge, the output equals ((n*step mod 65536) >> 8) > divisor.
- R4: The output is high only when the accumulator's upper byte is strictly greater than the active divisor. With step 0x0100, each 256-clock period has exactly 255 - divisor high clocks.
- R5: `wr_be[k]` enables writing byte k (bits 8k+7:8k). A write with `wr_be[3]` clear leaves the enable bit and the update bit unchanged.
- R6: Writing 1 to bit 30 sets the update request, and the bit reads 1 while the request is pending. Writing 0 to bit 30 has no effect. Changes to the shadow fields without a request never reach the output.
- R7: While enabled with a request pending, the shadow step and divisor are copied to the active settings at the clock edge on which the accumulator wraps. The request bit clears on that same edge.
- R8: While disabled, a pending request is applied at the next clock edge and the request bit clears.
- R9: Step values above 0x8002 are accepted without clamping and follow the same modulo-65536 arithmetic.
- R10: Reads return the shadow step in bits 23:8, the shadow divisor in bits 7:0, the enable bit, the request bit, and zeros elsewhere.
- R11: After re-enabling, the waveform restarts from zero phase regardless of the phase at which it was stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read value (combinational) |
| pwm_out | output | 1 | PWM output pin |

## Verification
The assertions check the following on every cycle:
- The accumulator either advances by exactly the active step or is held at zero while disabled.
- The active settings change only at a boundary with a pending request, and they then take the prior shadow values.
- A pending request clears at each boundary unless a write sets it again in the same cycle.
- A write without the top byte lane leaves the enable bit alone.

Only the bench scenarios show the following:
- The waveform as a whole matches the arithmetic formula for many steps, including steps beyond 0x8002.
- The high-time count is 255 - divisor across a sweep of divisors.
- A mid-period update takes effect exactly at the wrap.
- Re-enabling restarts from zero phase.

// File: rtl/frac_pwm_pkg.sv
// Shared constants and types for the fractional-rate PWM.
// Field positions are fixed because software decodes them.
package frac_pwm_pkg;
    localparam int REG_W    = 32;
    localparam int BYTES    = REG_W / 8;
    localparam int EN_BIT   = 31;
    localparam int UPD_BIT  = 30;
    localparam int STEP_W   = 16;
    localparam int STEP_LSB = 8;
    localparam int DIV_W    = 8;
    localparam int DIV_LSB  = 0;

    // One step/divisor setting, used for both the shadow and the active copy.
    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [DIV_W-1:0]  div;
    } pwm_cfg_t;
endpackage

// File: rtl/frac_pwm_regs.sv
// Register port: byte-laned write of the shadow settings and the enable bit.
// The update request is write-1-to-set and is cleared by hardware at a boundary.
// When a set and a clear arrive in the same cycle, the set wins.
// Assumes the boundary input is already qualified by the caller.
module frac_pwm_regs
    import frac_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BYTES-1:0] wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             boundary,
    output logic [REG_W-1:0] rd_data,
    output logic             run,
    output logic             pend,
    output pwm_cfg_t         shadow
);
    logic [REG_W-1:0]  bit_wr;
    logic [STEP_W-1:0] step_d;
    logic [DIV_W-1:0]  div_d;
    logic              run_d;
    logic              pend_d;
    logic              pend_set;

    // Expand each byte strobe into a per-bit write mask.
    genvar b;
    generate
        for (b = 0; b < BYTES; b++) begin : g_lane
            assign bit_wr[b*8 +: 8] = {8{wr_en & wr_be[b]}};
        end
    endgenerate

    // Compute the next field values from the masked write data.
    always_comb begin
        step_d = (shadow.step & ~bit_wr[STEP_LSB +: STEP_W]) |
                 (wr_data[STEP_LSB +: STEP_W] & bit_wr[STEP_LSB +: STEP_W]);
        div_d  = (shadow.div & ~bit_wr[DIV_LSB +: DIV_W]) |
                 (wr_data[DIV_LSB +: DIV_W] & bit_wr[DIV_LSB +: DIV_W]);
        run_d    = bit_wr[EN_BIT] ? wr_data[EN_BIT] : run;
        pend_set = bit_wr[UPD_BIT] & wr_data[UPD_BIT];
        if (pend_set)
            pend_d = 1'b1;
        else if (boundary)
            pend_d = 1'b0;
        else
            pend_d = pend;
    end

    // Hold the shadow settings, the enable bit and the request bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            run    <= 1'b0;
            pend   <= 1'b0;
        end else begin
            shadow.step <= step_d;
            shadow.div  <= div_d;
            run         <= run_d;
            pend        <= pend_d;
        end
    end

    // Assemble the read image; reserved bits read as zero.
    always_comb begin
        rd_data                       = '0;
        rd_data[EN_BIT]               = run;
        rd_data[UPD_BIT]              = pend;
        rd_data[STEP_LSB +: STEP_W]   = shadow.step;
        rd_data[DIV_LSB +: DIV_W]     = shadow.div;
    end
endmodule

// File: rtl/frac_pwm_phase.sv
// Phase accumulator: adds the step on every enabled clock and wraps modulo 2^W.
// Flags a wrap in the cycle whose addition carries out.
// The accumulator is held at zero while not running, so a restart begins at zero phase.
module frac_pwm_phase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] step,
    output logic [W-1:0] acc,
    output logic         wrap
);
    logic [W-1:0] sum;
    logic         carry;

    // Add the step with carry out.
    always_comb begin
        {carry, sum} = {1'b0, acc} + {1'b0, step};
        wrap         = run & carry;
    end

    // Advance the phase, or hold it at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (!run)
            acc <= '0;
        else
            acc <= sum;
    end
endmodule

// File: rtl/frac_pwm_drive.sv
// Active settings and output comparator.
// Loads the shadow settings at a boundary when a request is pending.
// The output is high while the phase's upper byte exceeds the active divisor.
// The output is combinational from registers, so it changes only after a clock edge.
module frac_pwm_drive
    import frac_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             boundary,
    input  logic             pend,
    input  pwm_cfg_t         shadow,
    input  logic [DIV_W-1:0] phase_hi,
    output pwm_cfg_t         active,
    output logic             pwm
);
    // Copy the shadow settings into the active ones on a requested boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= '0;
        else if (boundary && pend)
            active <= shadow;
    end

    // Compare the phase against the inverted duty, gated by enable.
    always_comb begin
        pwm = run && (phase_hi > active.div);
    end
endmodule

// File: rtl/frac_pwm.sv
// Top level of the single-channel fractional-rate PWM.
// A period boundary is a phase wrap, or any cycle while disabled.
// The disabled case lets software load settings before enabling.
module frac_pwm
    import frac_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    logic              run;
    logic              pend;
    logic              wrap;
    logic              boundary;
    logic [STEP_W-1:0] acc;
    pwm_cfg_t          shadow;
    pwm_cfg_t          active;

    // Combine the two sources of a period boundary.
    always_comb begin
        boundary = wrap | ~run;
    end

    frac_pwm_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .boundary (boundary),
        .rd_data  (rd_data),
        .run      (run),
        .pend     (pend),
        .shadow   (shadow)
    );

    frac_pwm_phase #(.W(STEP_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (active.step),
        .acc   (acc),
        .wrap  (wrap)
    );

    frac_pwm_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .boundary (boundary),
        .pend     (pend),
        .shadow   (shadow),
        .phase_hi (acc[STEP_W-1 -: DIV_W]),
        .active   (active),
        .pwm      (pwm_out)
    );
endmodule

// File: rtl/frac_pwm_chk.sv
// Cycle-level checker bound into frac_pwm.
// Observes the enable, the request, the phase and the active and shadow settings.
module frac_pwm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_top,
    input logic        wr_upd,
    input logic        rd_en,
    input logic        run,
    input logic        pend,
    input logic        boundary,
    input logic [15:0] acc,
    input logic [15:0] step_act,
    input logic [7:0]  div_act,
    input logic [15:0] step_sh,
    input logic [7:0]  div_sh
);
    // R2
    acc_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> acc == 16'd0);

    // R3
    acc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> acc == 16'($past(acc) + $past(step_act)));

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && boundary && !(wr_en && wr_top && wr_upd)) |=> !pend);

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(boundary && pend) |=> ($stable(step_act) && $stable(div_act)));

    // R7
    active_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && pend) |=> (step_act == $past(step_sh) && div_act == $past(div_sh)));

    // R8
    idle_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && pend && !(wr_en && wr_top)) |=> !pend);

    // R5
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_top) |=> rd_en == $past(rd_en));
endmodule

bind frac_pwm frac_pwm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_top   (wr_be[3]),
    .wr_upd   (wr_data[30]),
    .rd_en    (rd_data[31]),
    .run      (run),
    .pend     (pend),
    .boundary (boundary),
    .acc      (acc),
    .step_act (active.step),
    .div_act  (active.div),
    .step_sh  (shadow.step),
    .div_sh   (shadow.div)
);

// File: tb/sim_frac_pwm.sv
module sim_frac_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        pwm_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    frac_pwm u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input bit en, input bit up,
                                         input logic [15:0] s, input logic [7:0] d);
        return {en, up, 6'b0, s, d};
    endfunction

    // Single write; it lands on the posedge inside this task.
    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // Load settings while disabled, then enable (edge E).
    task automatic start(input logic [15:0] s, input logic [7:0] d);
        wr(4'hF, word(1'b0, 1'b1, s, d));
        wr(4'hF, word(1'b1, 1'b0, s, d));
    endtask

    task automatic stop(input logic [15:0] s, input logic [7:0] d, input string tag);
        wr(4'hF, word(1'b0, 1'b0, s, d));
        #1;
        chk(pwm_out == 1'b0, tag, pwm_out, 0);
    endtask

    // Sample the output after enabled edges n0..n_max and compare with the formula.
    task automatic run_wave(input logic [15:0] s, input logic [7:0] d0, input logic [7:0] d1,
                            input int sw_n, input int wr_n, input logic [31:0] wd,
                            input logic [3:0] wbe, input int n0, input int n_max,
                            output int mism, output int hi);
        mism = 0; hi = 0;
        for (int n = n0; n <= n_max; n++) begin
            logic [31:0] p;
            logic [7:0]  dv;
            logic        e;
            @(negedge clk);
            if (n == wr_n) begin
                wr_en = 1'b1; wr_be = wbe; wr_data = wd;
            end else begin
                wr_en = 1'b0;
            end
            @(posedge clk);
            #2;
            p  = 32'(n) * 32'(s);
            dv = (n >= sw_n) ? d1 : d0;
            e  = (p[15:8] > dv);
            if (pwm_out !== e) mism++;
            if (pwm_out) hi++;
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int mism, hi;
        logic [15:0] steps [7];
        steps = '{16'h1000, 16'h0300, 16'h0001, 16'h8002, 16'hC000, 16'hFFFF, 16'h0000};

        repeat (5) @(posedge clk);
        #2;
        chk(rd_data == 32'h0, "R1 reset read", rd_data, 0);
        chk(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 / R8: request reads pending, then applies on the next idle edge.
        wr(4'hF, word(1'b0, 1'b1, 16'h0100, 8'h40));
        #1;
        chk(rd_data[30] == 1'b1, "R6 request pending", rd_data[30], 1);
        chk(rd_data == word(1'b0, 1'b1, 16'h0100, 8'h40), "R10 read fields", rd_data,
            word(1'b0, 1'b1, 16'h0100, 8'h40));
        @(posedge clk);
        #2;
        chk(rd_data[30] == 1'b0, "R8 idle apply clears request", rd_data[30], 0);

        // R4: duty sweep with step 0x0100 (period 256).
        for (int d = 0; d <= 255; d += 5) begin
            start(16'h0100, 8'(d));
            run_wave(16'h0100, 8'(d), 8'(d), 100000, -1, 32'h0, 4'h0, 1, 256, mism, hi);
            chk(mism == 0, "R4 waveform vs divisor", mism, 0);
            chk(hi == 255 - d, "R4 high count", hi, 255 - d);
            stop(16'h0100, 8'(d), "R2 output low on disable");
        end

        // R2: output stays low while disabled even with divisor 0.
        start(16'h0100, 8'h00);
        run_wave(16'h0100, 8'h00, 8'h00, 100000, -1, 32'h0, 4'h0, 1, 40, mism, hi);
        stop(16'h0100, 8'h00, "R2 disable edge");
        hi = 0;
        repeat (20) begin
            @(posedge clk); #2;
            if (pwm_out) hi++;
        end
        chk(hi == 0, "R2 held low while disabled", hi, 0);

        // R3 / R9: step patterns, including steps above 0x8002 and zero.
        foreach (steps[i]) begin
            start(steps[i], 8'h7F);
            run_wave(steps[i], 8'h7F, 8'h7F, 100000, -1, 32'h0, 4'h0, 1, 600, mism, hi);
            chk(mism == 0, (steps[i] > 16'h8002) ? "R9 large step waveform" : "R3 step waveform",
                mism, 0);
            stop(steps[i], 8'h7F, "R2 disable after step run");
        end

        // R7 / R10: deferred update mid-period, applied at the wrap on edge 256.
        start(16'h0100, 8'd200);
        run_wave(16'h0100, 8'd200, 8'd20, 256, 100, word(1'b1, 1'b1, 16'h0100, 8'd20), 4'hF,
                 1, 100, mism, hi);
        chk(mism == 0, "R7 before request", mism, 0);
        chk(rd_data[30] == 1'b1, "R6 pending after request", rd_data[30], 1);
        chk(rd_data[7:0] == 8'd20, "R10 read shows shadow divisor", rd_data[7:0], 20);
        run_wave(16'h0100, 8'd200, 8'd20, 256, -1, 32'h0, 4'h0, 101, 255, mism, hi);
        chk(mism == 0, "R7 old divisor held until wrap", mism, 0);
        chk(rd_data[30] == 1'b1, "R7 pending until wrap", rd_data[30], 1);
        run_wave(16'h0100, 8'd200, 8'd20, 256, -1, 32'h0, 4'h0, 256, 520, mism, hi);
        chk(mism == 0, "R7 new divisor after wrap", mism, 0);
        chk(rd_data[30] == 1'b0, "R7 request cleared at wrap", rd_data[30], 0);
        stop(16'h0100, 8'd20, "R2 disable after update");

        // R5 / R6: low-lane write leaves enable and request alone; no request, no change.
        start(16'h0100, 8'd128);
        run_wave(16'h0100, 8'd128, 8'd128, 100000, 50, word(1'b0, 1'b1, 16'h0100, 8'd10),
                 4'b0011, 1, 400, mism, hi);
        chk(mism == 0, "R6 shadow change without request ignored", mism, 0);
        chk(rd_data[31] == 1'b1, "R5 enable kept", rd_data[31], 1);
        chk(rd_data[30] == 1'b0, "R5 request not set", rd_data[30], 0);
        chk(rd_data[7:0] == 8'd10, "R10 shadow divisor written", rd_data[7:0], 10);
        stop(16'h0100, 8'd10, "R2 disable after lane test");

        // R11: stop mid-phase, re-enable, waveform restarts at zero phase.
        start(16'h0300, 8'h40);
        run_wave(16'h0300, 8'h40, 8'h40, 100000, -1, 32'h0, 4'h0, 1, 37, mism, hi);
        stop(16'h0300, 8'h40, "R2 disable mid-phase");
        wr(4'hF, word(1'b1, 1'b0, 16'h0300, 8'h40));
        run_wave(16'h0300, 8'h40, 8'h40, 100000, -1, 32'h0, 4'h0, 1, 300, mism, hi);
        chk(mism == 0, "R11 fresh phase after re-enable", mism, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule